// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a serial test access port that follows the IEEE 1149.1 rules. A sixteen-state controller is stepped by the test mode select line on each rising edge of the test clock. It moves between an instruction path and a data path. The instruction path holds a three-bit code. That code picks one of three data registers to sit between the serial input and the serial output: a one-bit bypass cell, a 32-bit identification word or a boundary chain.

The boundary chain wraps the pins of the block that contains the port. It has one cell for each input pin, one cell for each output pin and one cell for the shared output enable. Depending on the active instruction, the pins carry the values from the core, the values held in the chain, or nothing at all (outputs switched off). The widths of the input and output groups and the three fields of the identification word are parameters. The chain length is derived from the two widths.

Top module: `scan_tap`

## Requirements
- R1: While trst_n is low, the controller sits in its reset state, tdo_en is 0, pad_out follows core_out, pad_oe follows core_oe, and the active instruction is IDCODE (code 001). A data scan done straight after reset shifts out the identification word.
- R2: Five rising tck edges with tms=1, starting from any state (Shift-DR included), return the controller to its reset state and make IDCODE the active instruction again.
- R3: In Capture-IR the instruction shift register loads 001, so the first three bits shifted out of an instruction scan are 1, 0, 0.
- R4: Under IDCODE (001), Capture-DR loads {ID_VERSION[3:0], ID_PART[15:0], ID_MAKER[10:0], 1'b1}. Shift-DR sends it out least significant bit first.
- R5: Under BYPASS (111), Capture-DR clears the one-bit bypass cell. The serial output then repeats the serial input one shift later, and the first bit out is 0.
- R6: The unused codes 101 and 110 act exactly like BYPASS.
- R7: Under SAMPLE/PRELOAD (010), Capture-DR loads the boundary chain with the pin-side values. Chain bit 0 (first out) is pad_oe, bits 1..N_OUT are pad_out[0..N_OUT-1], and the bits above those are pin_in[0..N_IN-1]. The pads keep following the core, and Update-DR loads chain bits N_OUT:0 into the output hold register.
- R8: Under EXTEST (000), pad_out and pad_oe come from the output hold register (pad_out[i] from chain bit i+1, pad_oe from chain bit 0). Capture-DR samples pin_in and the driven pad values with the layout of R7.
- R9: Under CLAMP (011), the bypass cell is the data register, and the pads keep the output hold register's values through a data scan.
- R10: Under HIGHZ (100), the bypass cell is the data register and pad_oe is 0.
- R11: tdo and tdo_en change only on the falling edge of tck. tdo_en is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R12: A newly shifted instruction takes effect only on the falling edge of tck in Update-IR (or in the reset state). Until then the pads keep their behaviour under the previous instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | High while tdo carries shift data |
| pin_in | input | N_IN | Values present on the input pins |
| core_out | input | N_OUT | Output values from the core logic |
| core_oe | input | 1 | Output enable from the core logic |
| pad_out | output | N_OUT | Values sent to the output pins |
| pad_oe | output | 1 | Output enable to the pins, 0 means high impedance |

## Verification
The bench builds the port with three input cells and four output cells, which gives an eight-bit chain. The layout of every cell can then be checked in a single scan. The identification fields are set to non-zero, asymmetric values, so a field placed at the wrong position or in the wrong order changes the shifted word. Because the chain is short, a preload under SAMPLE/PRELOAD, the switch to EXTEST, a second chain load and the CLAMP and HIGHZ phases all fit into one run. Core values that differ from the held values keep every pad source distinguishable.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET   = 4'h0,
      ST_IDLE    = 4'h1,
      ST_SEL_DR  = 4'h2,
      ST_CAP_DR  = 4'h3,
      ST_SH_DR   = 4'h4,
      ST_EX1_DR  = 4'h5,
      ST_PAU_DR  = 4'h6,
      ST_EX2_DR  = 4'h7,
      ST_UPD_DR  = 4'h8,
      ST_SEL_IR  = 4'h9,
      ST_CAP_IR  = 4'hA,
      ST_SH_IR   = 4'hB,
      ST_EX1_IR  = 4'hC,
      ST_PAU_IR  = 4'hD,
      ST_EX2_IR  = 4'hE,
      ST_UPD_IR  = 4'hF
   } tap_state_t;

   localparam int unsigned IR_W = 3;

   localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
   localparam logic [IR_W-1:0] INS_IDCODE = 3'b001;
   localparam logic [IR_W-1:0] INS_SAMPLE = 3'b010;
   localparam logic [IR_W-1:0] INS_CLAMP  = 3'b011;
   localparam logic [IR_W-1:0] INS_HIGHZ  = 3'b100;
   localparam logic [IR_W-1:0] INS_BYPASS = 3'b111;

   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

   typedef struct packed {
      logic sel_bsr;
      logic sel_id;
      logic sel_byp;
      logic drive_hold;
      logic pads_off;
   } ins_ctl_t;

   function automatic ins_ctl_t decode_ins(input logic [IR_W-1:0] code);
      ins_ctl_t c;
      c = '0;
      case (code)
         INS_EXTEST: begin
            c.sel_bsr    = 1'b1;
            c.drive_hold = 1'b1;
         end
         INS_SAMPLE: c.sel_bsr = 1'b1;
         INS_IDCODE: c.sel_id  = 1'b1;
         INS_CLAMP: begin
            c.sel_byp    = 1'b1;
            c.drive_hold = 1'b1;
         end
         INS_HIGHZ: begin
            c.sel_byp  = 1'b1;
            c.pads_off = 1'b1;
         end
         default: c.sel_byp = 1'b1;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_t state
);

   tap_state_t nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= nxt;
   end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  logic            in_reset,
   input  logic            cap,
   input  logic            shift,
   input  logic            upd,
   output logic            so,
   output logic [IR_W-1:0] active,
   output ins_ctl_t        ctl
);

   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (cap)   sr <= IR_CAPTURE;
      else if (shift) sr <= {tdi, sr[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)        active <= INS_IDCODE;
      else if (in_reset) active <= INS_IDCODE;
      else if (upd)      active <= sr;
   end

   assign so  = sr[0];
   assign ctl = decode_ins(active);

endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned N_OUT = 8
) (
   input  logic             tck,
   input  logic             rst_n,
   input  logic             tdi,
   input  logic             cap,
   input  logic             shift,
   input  logic             upd,
   input  logic             sel,
   input  logic             drive_hold,
   input  logic             pads_off,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_OUT-1:0] core_out,
   input  logic             core_oe,
   output logic [N_OUT-1:0] pad_out,
   output logic             pad_oe,
   output logic             so
);

   localparam int unsigned LEN    = N_IN + N_OUT + 1;
   localparam int unsigned HOLD_W = N_OUT + 1;
   localparam int unsigned IN_LO  = N_OUT + 1;

   logic [LEN-1:0]    sr;
   logic [LEN-1:0]    cap_vec;
   logic [HOLD_W-1:0] hold;

   assign cap_vec[0] = pad_oe;

   for (genvar i = 0; i < N_OUT; i++) begin : g_out_cell
      assign cap_vec[1+i] = pad_out[i];
   end

   for (genvar j = 0; j < N_IN; j++) begin : g_in_cell
      assign cap_vec[IN_LO+j] = pin_in[j];
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)              sr <= '0;
      else if (sel && cap)     sr <= cap_vec;
      else if (sel && shift)   sr <= {tdi, sr[LEN-1:1]};
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)          hold <= '0;
      else if (sel && upd) hold <= sr[HOLD_W-1:0];
   end

   always_comb begin
      if (drive_hold) begin
         pad_out = hold[HOLD_W-1:1];
         pad_oe  = hold[0];
      end else begin
         pad_out = core_out;
         pad_oe  = core_oe;
      end
      if (pads_off) pad_oe = 1'b0;
   end

   assign so = sr[0];

endmodule

// File: rtl/scan_tap.sv
module scan_tap
   import scan_tap_pkg::*;
#(
   parameter int unsigned N_IN       = 8,
   parameter int unsigned N_OUT      = 8,
   parameter logic [10:0] ID_MAKER   = 11'h000,
   parameter logic [15:0] ID_PART    = 16'h0000,
   parameter logic [3:0]  ID_VERSION = 4'h0,
   parameter bit          USE_TRST   = 1'b1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_en,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_OUT-1:0] core_out,
   input  logic             core_oe,
   output logic [N_OUT-1:0] pad_out,
   output logic             pad_oe
);

   localparam int unsigned ID_W    = 32;
   localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

   if (N_IN < 1) begin : g_bad_in
      $error("scan_tap: N_IN must be at least 1");
   end
   if (N_OUT < 1) begin : g_bad_out
      $error("scan_tap: N_OUT must be at least 1");
   end

   logic rst_n;
   if (USE_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      assign rst_n = 1'b1;
   end

   tap_state_t      state;
   logic [IR_W-1:0] ir_active;
   ins_ctl_t        ctl;
   logic            ir_so, bsr_so, dr_so;
   logic            byp_q;
   logic [ID_W-1:0] id_sr;
   logic            in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;

   assign in_reset = (state == ST_RESET);
   assign cap_dr   = (state == ST_CAP_DR);
   assign sh_dr    = (state == ST_SH_DR);
   assign upd_dr   = (state == ST_UPD_DR);
   assign cap_ir   = (state == ST_CAP_IR);
   assign sh_ir    = (state == ST_SH_IR);
   assign upd_ir   = (state == ST_UPD_IR);

   scan_tap_fsm u_fsm (
      .tck   (tck),
      .rst_n (rst_n),
      .tms   (tms),
      .state (state)
   );

   scan_tap_ir u_ir (
      .tck      (tck),
      .rst_n    (rst_n),
      .tdi      (tdi),
      .in_reset (in_reset),
      .cap      (cap_ir),
      .shift    (sh_ir),
      .upd      (upd_ir),
      .so       (ir_so),
      .active   (ir_active),
      .ctl      (ctl)
   );

   scan_tap_bsr #(
      .N_IN  (N_IN),
      .N_OUT (N_OUT)
   ) u_bsr (
      .tck        (tck),
      .rst_n      (rst_n),
      .tdi        (tdi),
      .cap        (cap_dr),
      .shift      (sh_dr),
      .upd        (upd_dr),
      .sel        (ctl.sel_bsr),
      .drive_hold (ctl.drive_hold),
      .pads_off   (ctl.pads_off),
      .pin_in     (pin_in),
      .core_out   (core_out),
      .core_oe    (core_oe),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .so         (bsr_so)
   );

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                     byp_q <= 1'b0;
      else if (ctl.sel_byp && cap_dr) byp_q <= 1'b0;
      else if (ctl.sel_byp && sh_dr)  byp_q <= tdi;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                    id_sr <= '0;
      else if (ctl.sel_id && cap_dr) id_sr <= ID_WORD;
      else if (ctl.sel_id && sh_dr)  id_sr <= {tdi, id_sr[ID_W-1:1]};
   end

   always_comb begin
      if (ctl.sel_bsr)     dr_so = bsr_so;
      else if (ctl.sel_id) dr_so = id_sr[0];
      else                 dr_so = byp_q;
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= sh_ir | sh_dr;
         if (sh_ir)      tdo <= ir_so;
         else if (sh_dr) tdo <= dr_so;
      end
   end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
   import scan_tap_pkg::*;
(
   input logic            tck,
   input logic            rst_n,
   input logic            tms,
   input logic            tdo_en,
   input logic            pad_oe,
   input tap_state_t      state,
   input logic [IR_W-1:0] ir_active
);

   // R1: leaving the reset state always leaves IDCODE active
   assert_reset_idcode_R1: assert property (@(negedge tck) disable iff (!rst_n)
      (state == ST_RESET) |=> (ir_active == INS_IDCODE));

   // R2: five rising edges with tms high reach the reset state
   assert_tms_reset_R2: assert property (@(posedge tck) disable iff (!rst_n)
      (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_RESET));

   // R10: outputs are switched off under HIGHZ
   assert_highz_off_R10: assert property (@(posedge tck) disable iff (!rst_n)
      (ir_active == INS_HIGHZ) |-> !pad_oe);

   // R11: output enable reflects the shift states of the half cycle before
   assert_tdo_en_shift_R11: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_en == ((state == ST_SH_DR) || (state == ST_SH_IR)));

   // R12: the active instruction moves only in Update-IR or the reset state
   assert_ir_update_only_R12: assert property (@(posedge tck) disable iff (!rst_n)
      !$stable(ir_active) |-> ((state == ST_UPD_IR) || (state == ST_RESET)));

endmodule

bind scan_tap scan_tap_chk u_chk (
   .tck       (tck),
   .rst_n     (rst_n),
   .tms       (tms),
   .tdo_en    (tdo_en),
   .pad_oe    (pad_oe),
   .state     (state),
   .ir_active (ir_active)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;

   localparam int N_IN  = 3;
   localparam int N_OUT = 4;
   localparam int LEN   = N_IN + N_OUT + 1;
   localparam logic [31:0] EXP_ID = {4'h9, 16'hC3E1, 11'h2A5, 1'b1};

   logic             tck = 1'b0;
   logic             trst_n = 1'b0;
   logic             tms = 1'b1;
   logic             tdi = 1'b0;
   logic             tdo, tdo_en;
   logic [N_IN-1:0]  pin_in = 3'b101;
   logic [N_OUT-1:0] core_out = 4'b1010;
   logic             core_oe = 1'b1;
   logic [N_OUT-1:0] pad_out;
   logic             pad_oe;

   int    checks = 0;
   int    errors = 0;
   bit    exp_q[$];
   string tag_q[$];

   always #10 tck = ~tck;

   scan_tap #(
      .N_IN(N_IN), .N_OUT(N_OUT),
      .ID_MAKER(11'h2A5), .ID_PART(16'hC3E1), .ID_VERSION(4'h9),
      .USE_TRST(1'b1)
   ) u_scan_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .tdo(tdo), .tdo_en(tdo_en),
      .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected bit for each cycle the design shifts out
   initial begin
      forever begin
         @(negedge tck);
         #5;
         if (tdo_en) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected tdo_en", 64'(tdo_en), 64'd0);
            end else begin
               bit    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(tdo == e, t, 64'(tdo), 64'(e));
            end
         end
      end
   end

   task automatic tick(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(negedge tck);
      #2;
   endtask

   task automatic push(input bit e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic load_ir(input logic [2:0] code, input bit chk_hold);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 3; i++) begin
         push(i == 0, "R3 capture pattern");
         tick(i == 2, code[i]);
      end
      if (chk_hold)
         check(pad_out == core_out && pad_oe == core_oe, "R12 pads before update",
               64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
      tick(1, 0);
      tick(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din,
                          input logic [63:0] exp, input string t);
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) begin
         push(exp[i], t);
         tick(i == n - 1, din[i]);
      end
      tick(1, 0);
      tick(0, 0);
   endtask

   function automatic logic [63:0] byp_exp(input logic [63:0] din);
      return {din[62:0], 1'b0};
   endfunction

   initial begin
      repeat (200000) @(posedge tck);
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge tck);
      #2;
      check(tdo_en == 1'b0, "R1 tdo_en in reset", 64'(tdo_en), 64'd0);
      check(pad_out == core_out && pad_oe == core_oe, "R1 pads in reset",
            64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
      trst_n = 1'b1;
      tick(0, 0);

      // R1 / R4: identification word straight after reset
      scan_dr(32, 64'h0, 64'(EXP_ID), "R4 id word after reset R1");
      check(tdo_en == 1'b0, "R11 idle tdo_en", 64'(tdo_en), 64'd0);

      // R5: bypass
      load_ir(3'b111, 1'b0);
      d = 64'hB2;
      scan_dr(8, d, byp_exp(d), "R5 bypass");

      // R6: unused codes
      load_ir(3'b101, 1'b0);
      d = 64'h6;
      scan_dr(4, d, byp_exp(d), "R6 code 101");
      load_ir(3'b110, 1'b0);
      d = 64'h9;
      scan_dr(4, d, byp_exp(d), "R6 code 110");

      // R2: five tms=1 clocks from Shift-DR
      load_ir(3'b111, 1'b0);
      tick(1, 0); tick(0, 0); tick(0, 0);
      push(1'b0, "R2 bypass first bit");
      for (int i = 0; i < 5; i++) tick(1, 0);
      tick(0, 0);
      scan_dr(32, 64'h0, 64'(EXP_ID), "R2 id after tms reset");

      // R7: sample and preload
      pin_in = 3'b011; core_out = 4'b0110; core_oe = 1'b1;
      load_ir(3'b010, 1'b0);
      d = 64'({3'b000, 4'b1001, 1'b1});
      scan_dr(LEN, d, 64'({pin_in, core_out, core_oe}), "R7 sample capture");
      check(pad_out == core_out && pad_oe == core_oe, "R7 pads follow core",
            64'({pad_out, pad_oe}), 64'({core_out, core_oe}));

      // R12 then R8: extest drives the preloaded values
      load_ir(3'b000, 1'b1);
      check(pad_out == 4'b1001 && pad_oe == 1'b1, "R8 extest preload drive",
            64'({pad_out, pad_oe}), 64'({4'b1001, 1'b1}));
      pin_in = 3'b110;
      d = 64'({3'b000, 4'b0101, 1'b1});
      scan_dr(LEN, d, 64'({3'b110, 4'b1001, 1'b1}), "R8 extest capture");
      check(pad_out == 4'b0101 && pad_oe == 1'b1, "R8 extest update",
            64'({pad_out, pad_oe}), 64'({4'b0101, 1'b1}));

      // R9: clamp
      load_ir(3'b011, 1'b0);
      check(pad_out == 4'b0101 && pad_oe == 1'b1, "R9 clamp holds",
            64'({pad_out, pad_oe}), 64'({4'b0101, 1'b1}));
      d = 64'h1A;
      scan_dr(5, d, byp_exp(d), "R9 clamp bypass");
      check(pad_out == 4'b0101 && pad_oe == 1'b1, "R9 clamp after scan",
            64'({pad_out, pad_oe}), 64'({4'b0101, 1'b1}));

      // R10: highz
      load_ir(3'b100, 1'b0);
      check(pad_oe == 1'b0, "R10 highz oe", 64'(pad_oe), 64'd0);
      d = 64'h5;
      scan_dr(3, d, byp_exp(d), "R10 highz bypass");
      check(pad_oe == 1'b0, "R10 highz after scan", 64'(pad_oe), 64'd0);

      // R1: asynchronous reset again
      trst_n = 1'b0;
      #3;
      check(pad_out == core_out && pad_oe == core_oe, "R1 pads after trst",
            64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
      trst_n = 1'b1;
      tick(0, 0);
      scan_dr(32, 64'h0, 64'(EXP_ID), "R1 id after trst");

      check(exp_q.size() == 0, "R11 all expected bits shifted",
            64'(exp_q.size()), 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule